// File: doc/BRIEF.md
# Frame-Adaptive Color Temperature Corrector

This block sits in a streaming video path and shifts the white balance of each picture toward one of three standard color temperatures. While a frame streams through, it finds that frame's brightest pixel, meaning the pixel with the largest sum of its red, green and blue codes. The triple of that pixel is taken as the frame's white point.

A frame boundary is marked by a rising vertical-sync marker. At each boundary the block latches the measured white point and the target selection. During blanking it then computes one scale ratio per channel: the target white value divided by the measured white value. Every pixel of the following frame is multiplied by these ratios, and the result is clipped to the largest code.

Pixels pass through unchanged in three cases. The first is when the block is set to its neutral selection. The second is when the measured white point already lies within a small tolerance of the target in every channel. The third applies per channel: a channel whose measured white value is zero keeps a ratio of exactly one.

Top module: `wp_temp_corrector`

## Requirements
- R1: While reset is high, and in the cycle after it, out_de, out_rdy and all three output channels are 0.
- R2: With the selection latched at a frame start equal to 0, every pixel of that frame leaves the block unchanged.
- R3: The target triples (R,G,B) are as follows. Selection 1 (6500K) is (1023,1010,960). Selection 2 (8000K) is (1000,1010,1023). Selection 3 (9300K) is (960,990,1023). For a non-neutral selection, each channel of every pixel in a frame is output as floor(in * ratio / 1024), where ratio = floor(target * 1024 / white). White is that channel of the previous frame's white point.
- R4: The white point is the first pixel, in stream order, whose R+G+B is strictly larger than that of every earlier pixel in the frame. Ties keep the earlier pixel.
- R5: A scaled value above 1023 is output as 1023.
- R6: Output data and out_de follow pix_de and the input pixel with a latency of exactly 2 clock cycles.
- R7: tgt_sel is sampled only in the cycle where pix_vsync rises. Changes at any other time have no effect on the current frame.
- R8: If all three channels of the measured white point lie within 8 codes (absolute difference at most 8) of the target, the frame passes through unchanged. A difference of 9 in any one channel enables correction.
- R9: A channel whose measured white value is 0 uses a ratio of exactly 1.0, so that channel passes through unchanged.
- R10: In the first frame after reset no white point has been measured, so that frame passes through unchanged.
- R11: out_rdy is high exactly when out_de is high for a pixel that entered while no ratio computation was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_r | input | 10 | Red input code |
| pix_g | input | 10 | Green input code |
| pix_b | input | 10 | Blue input code |
| pix_de | input | 1 | Input pixel is active |
| pix_vsync | input | 1 | Vertical sync; its rising edge starts a frame |
| tgt_sel | input | 2 | Target select: 0 neutral, 1 6500K, 2 8000K, 3 9300K |
| out_r | output | 10 | Corrected red code |
| out_g | output | 10 | Corrected green code |
| out_b | output | 10 | Corrected blue code |
| out_de | output | 1 | pix_de delayed by two cycles |
| out_rdy | output | 1 | Corrected data valid for the next stage |

## Verification
The assertions assume that pix_de is low while pix_vsync is high. They also assume that at least 24 cycles pass between a rising pix_vsync and the next active pixel, so that the ratio computation finishes inside blanking. A further assumption is that two frame starts are never closer than a few cycles. The stimulus holds vsync high for 4 cycles with de low, leaves 30 idle cycles before the first pixel, and flushes several idle cycles at the end of each frame. Random gaps are placed only inside the active region.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int CHAN_W = 10;
  localparam int NCH    = 3;

  typedef logic [CHAN_W-1:0] chan_t;
  typedef struct packed {
    chan_t r;
    chan_t g;
    chan_t b;
  } rgb_t;

  // target white triples, one per temperature selection; 0 means neutral
  function automatic rgb_t target_wp(input logic [1:0] sel);
    rgb_t t;
    case (sel)
      2'd1:    t = '{r: chan_t'(1023), g: chan_t'(1010), b: chan_t'(960)};
      2'd2:    t = '{r: chan_t'(1000), g: chan_t'(1010), b: chan_t'(1023)};
      2'd3:    t = '{r: chan_t'(960),  g: chan_t'(990),  b: chan_t'(1023)};
      default: t = '0;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/wp_tracker.sv
module wp_tracker
  import wp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic de,
  input  rgb_t pix,
  output rgb_t wp
);
  localparam int SUM_W = CHAN_W + 2;

  logic [SUM_W-1:0] best_q;
  logic [SUM_W-1:0] sum_c;

  assign sum_c = SUM_W'(pix.r) + SUM_W'(pix.g) + SUM_W'(pix.b);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      best_q <= '0;
      wp     <= '0;
    end else if (de && (sum_c > best_q)) begin
      best_q <= sum_c;
      wp     <= pix;
    end
  end
endmodule

// File: rtl/wp_ratio_div.sv
module wp_ratio_div #(
  parameter int CW   = 10,
  parameter int FRAC = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CW-1:0]    num_hi,
  input  logic [CW-1:0]    den,
  output logic             busy,
  output logic             done,
  output logic [CW+FRAC-1:0] quo
);
  localparam int RW  = CW + FRAC;
  localparam int CNW = $clog2(RW + 1);
  localparam logic [RW-1:0] ONE = RW'(1) << FRAC;

  logic [CNW-1:0] cnt_q;
  logic [RW-1:0]  nsh_q, q_q;
  logic [CW-1:0]  rem_q, den_q;
  logic [CW:0]    rem_sh;
  logic           fits;

  assign rem_sh = {rem_q, nsh_q[RW-1]};
  assign fits   = rem_sh >= {1'b0, den_q};
  assign quo    = (den_q == '0) ? ONE : q_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0; nsh_q <= '0; q_q <= '0; rem_q <= '0; den_q <= '0;
      busy  <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        nsh_q <= {num_hi, {FRAC{1'b0}}};
        rem_q <= '0;
        q_q   <= '0;
        den_q <= den;
        cnt_q <= CNW'(RW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? CW'(rem_sh - {1'b0, den_q}) : rem_sh[CW-1:0];
        q_q   <= {q_q[RW-2:0], fits};
        nsh_q <= nsh_q << 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wp_scaler.sv
module wp_scaler #(
  parameter int CW   = 10,
  parameter int FRAC = 10,
  parameter int N    = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   de,
  input  logic                   ok,
  input  logic [N*CW-1:0]        in_bus,
  input  logic [N*(CW+FRAC)-1:0] ratio_bus,
  output logic [N*CW-1:0]        out_bus,
  output logic                   out_de,
  output logic                   out_ok
);
  localparam int RW = CW + FRAC;
  localparam int PW = CW + RW;

  logic de_q, ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      de_q <= 1'b0; ok_q <= 1'b0; out_de <= 1'b0; out_ok <= 1'b0;
    end else begin
      de_q   <= de;
      ok_q   <= de & ok;
      out_de <= de_q;
      out_ok <= ok_q;
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_ch
    logic [PW-1:0] prod_q;
    logic [RW-1:0] shifted;
    assign shifted = prod_q[PW-1:FRAC];

    always_ff @(posedge clk) begin
      if (rst) begin
        prod_q                <= '0;
        out_bus[c*CW +: CW]   <= '0;
      end else begin
        prod_q              <= PW'(in_bus[c*CW +: CW]) * PW'(ratio_bus[c*RW +: RW]);
        out_bus[c*CW +: CW] <= (|shifted[RW-1:CW]) ? {CW{1'b1}} : shifted[CW-1:0];
      end
    end
  end
endmodule

// File: rtl/wp_temp_corrector.sv
module wp_temp_corrector
  import wp_pkg::*;
#(
  parameter int FRAC_W = 10,
  parameter int DELTA  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CHAN_W-1:0] pix_r,
  input  logic [CHAN_W-1:0] pix_g,
  input  logic [CHAN_W-1:0] pix_b,
  input  logic              pix_de,
  input  logic              pix_vsync,
  input  logic [1:0]        tgt_sel,
  output logic [CHAN_W-1:0] out_r,
  output logic [CHAN_W-1:0] out_g,
  output logic [CHAN_W-1:0] out_b,
  output logic              out_de,
  output logic              out_rdy
);
  localparam int RW = CHAN_W + FRAC_W;
  localparam logic [RW-1:0] ONE = RW'(1) << FRAC_W;

  logic vs_q, frame_start, skip, busy_any, done_any;
  rgb_t pix_in, wp, tgt;
  chan_t wp_ch [NCH];
  chan_t tgt_ch [NCH];
  logic [NCH-1:0] near, busy, done;
  logic [NCH*RW-1:0] ratio_bus;
  logic [NCH*CHAN_W-1:0] in_bus, out_bus;

  assign pix_in      = '{r: pix_r, g: pix_g, b: pix_b};
  assign frame_start = pix_vsync & ~vs_q;
  assign tgt         = target_wp(tgt_sel);
  assign wp_ch[0] = wp.r;  assign wp_ch[1] = wp.g;  assign wp_ch[2] = wp.b;
  assign tgt_ch[0] = tgt.r; assign tgt_ch[1] = tgt.g; assign tgt_ch[2] = tgt.b;
  assign skip     = (tgt_sel == 2'd0) || (&near);
  assign busy_any = |busy;
  assign done_any = |done;
  assign in_bus   = {pix_b, pix_g, pix_r};
  assign {out_b, out_g, out_r} = out_bus;

  always_ff @(posedge clk) begin
    if (rst) vs_q <= 1'b0;
    else     vs_q <= pix_vsync;
  end

  wp_tracker u_track (
    .clk(clk), .rst(rst), .clr(frame_start), .de(pix_de), .pix(pix_in), .wp(wp)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ratio
    chan_t            diff;
    logic [RW-1:0]    quo;
    logic [RW-1:0]    ratio_q;

    assign diff    = (wp_ch[c] > tgt_ch[c]) ? (wp_ch[c] - tgt_ch[c]) : (tgt_ch[c] - wp_ch[c]);
    assign near[c] = diff <= CHAN_W'(DELTA);

    wp_ratio_div #(.CW(CHAN_W), .FRAC(FRAC_W)) u_div (
      .clk(clk), .rst(rst), .start(frame_start & ~skip),
      .num_hi(tgt_ch[c]), .den(wp_ch[c]),
      .busy(busy[c]), .done(done[c]), .quo(quo)
    );

    always_ff @(posedge clk) begin
      if (rst)                      ratio_q <= ONE;
      else if (frame_start && skip) ratio_q <= ONE;
      else if (done[c])             ratio_q <= quo;
    end
    assign ratio_bus[c*RW +: RW] = ratio_q;
  end

  wp_scaler #(.CW(CHAN_W), .FRAC(FRAC_W), .N(NCH)) u_scale (
    .clk(clk), .rst(rst), .de(pix_de), .ok(~busy_any),
    .in_bus(in_bus), .ratio_bus(ratio_bus),
    .out_bus(out_bus), .out_de(out_de), .out_ok(out_rdy)
  );
endmodule

// File: rtl/wp_temp_corrector_chk.sv
module wp_temp_corrector_chk #(
  parameter int CW = 10,
  parameter int RW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_de,
  input logic [1:0]    tgt_sel,
  input logic [CW-1:0] pix_r,
  input logic [CW-1:0] out_r,
  input logic          out_de,
  input logic          out_rdy,
  input logic          frame_start,
  input logic          done_any,
  input logic [3*RW-1:0] ratio_bus
);
  logic [1:0] since_rst;
  logic       neutral_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      neutral_q <= 1'b0;
    end else begin
      if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
      if (frame_start) neutral_q <= (tgt_sel == 2'd0);
    end
  end

  // R1
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!out_de && !out_rdy && out_r == '0));
  // R6
  p_de_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_de == $past(pix_de, 2)));
  // R2
  p_neutral_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && out_de && $past(neutral_q, 2) && $past(neutral_q, 1)) |-> (out_r == $past(pix_r, 2)));
  // R11
  p_rdy_has_de_r11: assert property (@(posedge clk) disable iff (rst) out_rdy |-> out_de);
  // R3: ratios change only after a frame start or a finished division
  p_ratio_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd1 && !$past(frame_start) && !$past(done_any)) |-> $stable(ratio_bus));
endmodule

bind wp_temp_corrector wp_temp_corrector_chk #(.CW(wp_pkg::CHAN_W), .RW(RW)) chk_i (
  .clk(clk), .rst(rst), .pix_de(pix_de), .tgt_sel(tgt_sel), .pix_r(pix_r),
  .out_r(out_r), .out_de(out_de), .out_rdy(out_rdy),
  .frame_start(frame_start), .done_any(done_any), .ratio_bus(ratio_bus)
);

// File: tb/wp_temp_corrector_tb.sv
module wp_temp_corrector_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [9:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic pix_de = 1'b0, pix_vsync = 1'b0;
  logic [1:0] tgt_sel = '0;
  logic [9:0] out_r, out_g, out_b;
  logic out_de, out_rdy;

  wp_temp_corrector dut_i (
    .clk(clk), .rst(rst), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .pix_de(pix_de), .pix_vsync(pix_vsync), .tgt_sel(tgt_sel),
    .out_r(out_r), .out_g(out_g), .out_b(out_b), .out_de(out_de), .out_rdy(out_rdy)
  );

  int n_tests = 0, n_fail = 0;
  string req = "R1";
  int ratio_m [3];
  int wp_m [3];
  int best_m = 0;
  bit h1_de = 0, h2_de = 0;
  int h1 [3];
  int h2 [3];

  function automatic int tgt_val(int sel, int c);
    case (sel)
      1: return (c == 0) ? 1023 : (c == 1) ? 1010 : 960;
      2: return (c == 0) ? 1000 : (c == 1) ? 1010 : 1023;
      3: return (c == 0) ? 960  : (c == 1) ? 990  : 1023;
      default: return 0;
    endcase
  endfunction

  function automatic int scale(int x, int rt);
    longint v = (longint'(x) * rt) >>> 10;
    return (v > 1023) ? 1023 : int'(v);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(bit de, int r, int g, int b, bit vs);
    int px [3];
    @(negedge clk);
    if (h2_de || out_de) begin
      check("R6", int'(out_de), int'(h2_de));
      if (h2_de) begin
        check(req, int'(out_r), h2[0]);
        check(req, int'(out_g), h2[1]);
        check(req, int'(out_b), h2[2]);
        check("R11", int'(out_rdy), 1);
      end
    end
    px[0] = r; px[1] = g; px[2] = b;
    h2_de = h1_de; h2 = h1;
    h1_de = de;
    for (int c = 0; c < 3; c++) h1[c] = scale(px[c], ratio_m[c]);
    if (de && (r + g + b > best_m)) begin
      best_m = r + g + b; wp_m = px;
    end
    pix_de = de; pix_vsync = vs;
    pix_r = 10'(r); pix_g = 10'(g); pix_b = 10'(b);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
  endtask

  task automatic start_frame(int sel);
    bit near = 1;
    for (int c = 0; c < 3; c++) begin
      int d = wp_m[c] - tgt_val(sel, c);
      if (d > 8 || d < -8) near = 0;
    end
    for (int c = 0; c < 3; c++) begin
      if (sel == 0 || near || wp_m[c] == 0) ratio_m[c] = 1024;
      else ratio_m[c] = (tgt_val(sel, c) * 1024) / wp_m[c];
    end
    best_m = 0; wp_m = '{0, 0, 0};
    tgt_sel = 2'(sel);
    for (int i = 0; i < 4; i++) tick(0, 0, 0, 0, 1);
    idle(30);
  endtask

  task automatic rand_pixels(int n, int lim, bit wiggle);
    for (int i = 0; i < n; i++) begin
      if ($urandom % 5 == 0) tick(0, 0, 0, 0, 0);
      if (wiggle && $urandom % 4 == 0) tgt_sel = 2'($urandom % 4); // R7
      tick(1, $urandom % lim, $urandom % lim, $urandom % lim, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    ratio_m = '{1024, 1024, 1024};
    wp_m = '{0, 0, 0};
    h1 = '{0, 0, 0}; h2 = '{0, 0, 0};
    repeat (4) @(negedge clk);
    check("R1", int'(out_de), 0);
    check("R1", int'(out_rdy), 0);
    check("R1", int'({out_r, out_g, out_b}), 0);
    @(negedge clk); rst = 1'b0;
    check("R1", int'(out_de), 0);
    check("R1", int'(out_r), 0);

    req = "R10"; start_frame(1); rand_pixels(40, 1024, 0); idle(4);
    req = "R3";  start_frame(2); rand_pixels(40, 1024, 0); idle(4);
    req = "R3";  start_frame(3);
    tick(1, 500, 400, 300, 0); tick(1, 100, 100, 100, 0); tick(1, 200, 50, 20, 0); idle(4);
    req = "R5";  start_frame(1);
    tick(1, 1023, 1023, 1023, 0); tick(1, 800, 700, 600, 0); tick(1, 300, 300, 300, 0); idle(4);
    req = "R4";  start_frame(2);
    tick(1, 600, 300, 300, 0); tick(1, 300, 600, 300, 0); tick(1, 100, 100, 100, 0); idle(4);
    req = "R4";  start_frame(1);
    tick(1, 1000, 0, 1000, 0); tick(1, 50, 60, 70, 0); tick(1, 900, 20, 900, 0); idle(4);
    req = "R9";  start_frame(1); rand_pixels(20, 512, 0);
    tick(1, 1020, 1015, 955, 0); idle(4);
    req = "R8";  start_frame(1); rand_pixels(20, 512, 0);
    tick(1, 1014, 1010, 960, 0); idle(4);
    req = "R8";  start_frame(1); rand_pixels(20, 1024, 0); idle(4);
    req = "R2";  start_frame(0); rand_pixels(30, 1024, 0); idle(4);
    for (int f = 0; f < 8; f++) begin
      req = "R7"; start_frame($urandom % 4); rand_pixels(50, 1024, 1); idle(4);
    end
    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule